// File: doc/BRIEF.md
# Shared Last-Level Cache Admission Front End

This block sits in front of a last-level cache that serves several cores. It decides, one request per cycle, which core may enter the cache. It keeps a table of misses that are still outstanding and a buffer of evicted dirty lines that have not yet been written out. A simplified tag lookup upstream marks each request as a hit or a miss. For a miss, the lookup also says whether the line it displaces is dirty and gives that victim's line address. The block turns misses into refill reads and victims into deferred writes on a single lower-level memory port. It signals completion to each core with a one-cycle response pulse.

Misses are non-blocking. While the miss table and the victim buffer both have room, hits and fresh misses keep flowing alongside outstanding refills. A second miss to a line that is already being fetched joins the existing entry and issues no new read. A miss to a line still waiting in the victim buffer is answered from the buffer, and that line leaves the buffer without being written. If either structure is full, the whole cache refuses every core, hits included, until an entry frees. Both free-entry counts and a saturating count of refused cycles are brought out so that this stall can be observed.

Top module: `llc_admit_front`

## Requirements
- R1: After reset, `mshr_free` equals MSHR_N, `wb_free` equals WB_N, `blocked_cycles` is 0, and `mem_req_valid` and `core_resp_valid` are low.
- R2: A granted request with `core_req_miss`=0 raises `core_resp_valid` for that core alone in the next cycle, and it causes no memory request.
- R3: A granted miss whose line is in neither the miss table nor the victim buffer takes one table entry (`mshr_free` drops by 1) and presents a read (`mem_req_write`=0) of that line. The entry frees, and the core gets its response pulse, in the cycle after `mem_rsp_valid` returns that line.
- R4: A miss to a line that already holds a table entry takes no entry and issues no read. Every core merged into the entry gets its response pulse in the cycle after the single refill returns. This includes a merge that is granted in the same cycle as that refill response.
- R5: A newly allocating miss with `core_req_vic_dirty`=1 places its victim line in the victim buffer (`wb_free` drops by 1). That line is later presented as a write (`mem_req_write`=1).
- R6: A write is presented on the memory port only when no table entry is waiting to issue its read. When both are pending, the read is presented first.
- R7: Whenever `mshr_free` or `wb_free` is 0, `core_req_ready` is all zero, for hits as well as misses.
- R8: A miss to a line held in the victim buffer is answered in the next cycle. It frees that buffer entry, takes no table entry, ignores its own victim, and the line is never written to memory.
- R9: At most one `core_req_ready` bit is high in a cycle, and only for a requesting core. The search starts at the core after the last one granted. A cycle with no grant leaves the search start unchanged.
- R10: A core with a miss still outstanding is not granted again until its response pulse.
- R11: `blocked_cycles` increases by 1 in each cycle where the cache is full (as in R7) and some `core_req_valid` bit is high. It saturates at all ones and is cleared only by reset.
- R12: While both structures have room, a new request is granted even though other misses are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | NCORES | Request pending, per core; held until granted |
| core_req_line | input | NCORES x LINE_W | Requested line address, per core |
| core_req_miss | input | NCORES | Tag lookup result: 1 = miss |
| core_req_vic_dirty | input | NCORES | The miss displaces a dirty line |
| core_req_vic_line | input | NCORES x LINE_W | Line address of the displaced line |
| core_req_ready | output | NCORES | One-hot grant; request accepted at this edge |
| core_resp_valid | output | NCORES | One-cycle completion pulse, per core |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_write | output | 1 | 1 = write of a victim line, 0 = refill read |
| mem_req_line | output | LINE_W | Line address of the memory request |
| mem_req_ready | input | 1 | Memory accepts the presented request |
| mem_rsp_valid | input | 1 | A refill line returns |
| mem_rsp_line | input | LINE_W | Line address of the returning refill |
| mshr_free | output | clog2(MSHR_N+1) | Free miss-table entries |
| wb_free | output | clog2(WB_N+1) | Free victim-buffer entries |
| blocked_cycles | output | CNT_W | Saturating count of refused cycles |

## Verification
A refill return and a new miss to that same line can land in one cycle. The returning entry frees at the same edge that the merge would join it, so the newcomer's response could be lost or a duplicate read issued. The bench provokes this by raising the refill response and a second core's miss to the line on the same edge. It judges the result by both cores pulsing together in the next cycle, the table count returning to full, and the memory port staying idle. A second overlap is also checked: a victim write waiting on the port while a read becomes pending. The bench confirms that the read is presented first.

// File: rtl/llc_admit_pkg.sv
package llc_admit_pkg;

  // Kind of transfer on the lower-level memory port
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;

endpackage

// File: rtl/llc_rr_arbiter.sv
module llc_rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] last_nxt;

  // Search starts one past the last winner
  always_comb begin
    logic          found;
    logic [IW-1:0] pos;
    gnt   = '0;
    found = 1'b0;
    pos   = '0;
    for (int k = 1; k <= N; k++) begin
      pos = IW'((int'(last_q) + k) % N);
      if (en && !found && req[pos]) begin
        gnt[pos] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    last_nxt = last_q;
    for (int i = 0; i < N; i++)
      if (gnt[i]) last_nxt = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(N - 1);
    else     last_q <= last_nxt;
  end
endmodule

// File: rtl/llc_miss_table.sv
module llc_miss_table #(
  parameter int N  = 4,
  parameter int NC = 4,
  parameter int LW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] look_line,
  output logic          match,
  input  logic          alloc_en,
  input  logic          merge_en,
  input  logic [NC-1:0] core_mask,
  output logic          iss_valid,
  output logic [LW-1:0] iss_line,
  input  logic          iss_fire,
  input  logic          rsp_valid,
  input  logic [LW-1:0] rsp_line,
  output logic [NC-1:0] done_mask,
  output logic [CW-1:0] free_cnt
);
  logic [N-1:0]  vld_q, sent_q;
  logic [LW-1:0] line_q [N];
  logic [NC-1:0] wait_q [N];

  logic [IW-1:0] match_idx, free_idx, iss_idx, rsp_idx;
  logic          rsp_hit;

  always_comb begin
    match = 1'b0; match_idx = '0;
    rsp_hit = 1'b0; rsp_idx = '0;
    iss_valid = 1'b0; iss_idx = '0;
    free_idx = '0; free_cnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && line_q[i] == look_line) begin
        match = 1'b1; match_idx = IW'(i);
      end
      if (vld_q[i] && sent_q[i] && line_q[i] == rsp_line) begin
        rsp_hit = rsp_valid; rsp_idx = IW'(i);
      end
      if (vld_q[i] && !sent_q[i]) begin
        iss_valid = 1'b1; iss_idx = IW'(i);
      end
      if (!vld_q[i]) begin
        free_idx = IW'(i); free_cnt = free_cnt + CW'(1);
      end
    end
  end

  assign iss_line = line_q[iss_idx];

  // A merge landing on the entry that retires this cycle is answered with it
  always_comb begin
    done_mask = '0;
    if (rsp_hit) begin
      done_mask = wait_q[rsp_idx];
      if (merge_en && match_idx == rsp_idx) done_mask = done_mask | core_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      sent_q <= '0;
      for (int i = 0; i < N; i++) begin
        line_q[i] <= '0;
        wait_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rsp_hit && rsp_idx == IW'(i)) begin
          vld_q[i] <= 1'b0;
        end else if (alloc_en && free_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          sent_q[i] <= 1'b0;
          line_q[i] <= look_line;
          wait_q[i] <= core_mask;
        end else begin
          if (merge_en && match_idx == IW'(i)) wait_q[i] <= wait_q[i] | core_mask;
          if (iss_fire && iss_idx == IW'(i))   sent_q[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/llc_victim_buf.sv
module llc_victim_buf #(
  parameter int N  = 4,
  parameter int LW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [LW-1:0] push_line,
  input  logic [LW-1:0] look_line,
  output logic          match,
  input  logic          take_en,
  output logic          drain_valid,
  output logic [LW-1:0] drain_line,
  input  logic          drain_fire,
  output logic [CW-1:0] free_cnt
);
  logic [N-1:0]  vld_q;
  logic [LW-1:0] line_q [N];
  logic [IW-1:0] match_idx, free_idx, drain_idx;

  always_comb begin
    match = 1'b0; match_idx = '0;
    drain_valid = 1'b0; drain_idx = '0;
    free_idx = '0; free_cnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && line_q[i] == look_line) begin
        match = 1'b1; match_idx = IW'(i);
      end
      if (vld_q[i]) begin
        drain_valid = 1'b1; drain_idx = IW'(i);
      end else begin
        free_idx = IW'(i); free_cnt = free_cnt + CW'(1);
      end
    end
  end

  assign drain_line = line_q[drain_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) line_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if ((take_en && match_idx == IW'(i)) || (drain_fire && drain_idx == IW'(i)))
          vld_q[i] <= 1'b0;
        else if (push_en && free_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= push_line;
        end
      end
    end
  end
endmodule

// File: rtl/llc_admit_front.sv
module llc_admit_front
  import llc_admit_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int LINE_W = 16,
  parameter int MSHR_N = 4,
  parameter int WB_N   = 4,
  parameter int CNT_W  = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NCORES-1:0]                core_req_valid,
  input  logic [NCORES-1:0][LINE_W-1:0]    core_req_line,
  input  logic [NCORES-1:0]                core_req_miss,
  input  logic [NCORES-1:0]                core_req_vic_dirty,
  input  logic [NCORES-1:0][LINE_W-1:0]    core_req_vic_line,
  output logic [NCORES-1:0]                core_req_ready,
  output logic [NCORES-1:0]                core_resp_valid,
  output logic                             mem_req_valid,
  output logic                             mem_req_write,
  output logic [LINE_W-1:0]                mem_req_line,
  input  logic                             mem_req_ready,
  input  logic                             mem_rsp_valid,
  input  logic [LINE_W-1:0]                mem_rsp_line,
  output logic [$clog2(MSHR_N+1)-1:0]      mshr_free,
  output logic [$clog2(WB_N+1)-1:0]        wb_free,
  output logic [CNT_W-1:0]                 blocked_cycles
);
  logic [NCORES-1:0] gnt, eligible, busy_q, done_mask;
  logic [LINE_W-1:0] sel_line, sel_vline, m_iss_line, wb_drain_line;
  logic              blocked, any_gnt, sel_miss, sel_vd;
  logic              m_match, m_iss_valid, wb_match, wb_drain_valid;
  logic              alloc_en, merge_en, take_en, push_en, hit_serve;
  logic              iss_fire, drain_fire;
  mem_op_e           op;

  // Either structure exhausted: nobody enters, hits included
  assign blocked  = (mshr_free == '0) || (wb_free == '0);
  assign eligible = core_req_valid & ~busy_q;

  llc_rr_arbiter #(.N(NCORES)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (eligible),
    .en  (!blocked),
    .gnt (gnt)
  );

  always_comb begin
    sel_line  = '0;
    sel_vline = '0;
    sel_miss  = 1'b0;
    sel_vd    = 1'b0;
    for (int i = 0; i < NCORES; i++) begin
      if (gnt[i]) begin
        sel_line  = core_req_line[i];
        sel_vline = core_req_vic_line[i];
        sel_miss  = core_req_miss[i];
        sel_vd    = core_req_vic_dirty[i];
      end
    end
  end

  assign any_gnt   = |gnt;
  assign take_en   = any_gnt && sel_miss && wb_match;
  assign merge_en  = any_gnt && sel_miss && !wb_match && m_match;
  assign alloc_en  = any_gnt && sel_miss && !wb_match && !m_match;
  assign push_en   = alloc_en && sel_vd;
  assign hit_serve = any_gnt && (!sel_miss || wb_match);

  llc_miss_table #(.N(MSHR_N), .NC(NCORES), .LW(LINE_W)) u_mshr (
    .clk       (clk),
    .rst       (rst),
    .look_line (sel_line),
    .match     (m_match),
    .alloc_en  (alloc_en),
    .merge_en  (merge_en),
    .core_mask (gnt),
    .iss_valid (m_iss_valid),
    .iss_line  (m_iss_line),
    .iss_fire  (iss_fire),
    .rsp_valid (mem_rsp_valid),
    .rsp_line  (mem_rsp_line),
    .done_mask (done_mask),
    .free_cnt  (mshr_free)
  );

  llc_victim_buf #(.N(WB_N), .LW(LINE_W)) u_wb (
    .clk         (clk),
    .rst         (rst),
    .push_en     (push_en),
    .push_line   (sel_vline),
    .look_line   (sel_line),
    .match       (wb_match),
    .take_en     (take_en),
    .drain_valid (wb_drain_valid),
    .drain_line  (wb_drain_line),
    .drain_fire  (drain_fire),
    .free_cnt    (wb_free)
  );

  // Refill reads always win the single memory port
  assign op            = m_iss_valid ? OP_READ : OP_WRITE;
  assign mem_req_valid = m_iss_valid || wb_drain_valid;
  assign mem_req_write = (op == OP_WRITE);
  assign mem_req_line  = (op == OP_READ) ? m_iss_line : wb_drain_line;
  assign iss_fire      = mem_req_ready && m_iss_valid;
  assign drain_fire    = mem_req_ready && !m_iss_valid && wb_drain_valid;

  assign core_req_ready = gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_resp_valid <= '0;
      busy_q          <= '0;
      blocked_cycles  <= '0;
    end else begin
      core_resp_valid <= (hit_serve ? gnt : '0) | done_mask;
      busy_q          <= (busy_q | ((alloc_en || merge_en) ? gnt : '0)) & ~done_mask;
      if (blocked && (|core_req_valid) && (blocked_cycles != '1))
        blocked_cycles <= blocked_cycles + CNT_W'(1);
    end
  end
endmodule

// File: rtl/llc_admit_front_chk.sv
module llc_admit_front_chk #(
  parameter int NC  = 4,
  parameter int MN  = 4,
  parameter int WN  = 4,
  parameter int CW  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NC-1:0]             core_req_valid,
  input logic [NC-1:0]             core_req_miss,
  input logic [NC-1:0]             core_req_ready,
  input logic [NC-1:0]             core_resp_valid,
  input logic [$clog2(MN+1)-1:0]   mshr_free,
  input logic [$clog2(WN+1)-1:0]   wb_free,
  input logic [CW-1:0]             blocked_cycles
);
  // R7
  full_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (mshr_free == '0 || wb_free == '0) |-> core_req_ready == '0);

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_req_ready) && ((core_req_ready & ~core_req_valid) == '0));

  // R3
  mshr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(mshr_free) <= MN && int'(wb_free) <= WN);

  // R3
  mshr_step_chk: assert property (@(posedge clk) disable iff (rst)
    int'(mshr_free) + 1 >= int'($past(mshr_free)) && int'(mshr_free) <= int'($past(mshr_free)) + 1);

  // R11
  blk_mono_chk: assert property (@(posedge clk) disable iff (rst)
    blocked_cycles >= $past(blocked_cycles));

  for (genvar i = 0; i < NC; i++) begin : g_hit
    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
      (core_req_ready[i] && !core_req_miss[i]) |=> core_resp_valid[i]);
  end
endmodule

bind llc_admit_front llc_admit_front_chk #(
  .NC(NCORES), .MN(MSHR_N), .WN(WB_N), .CW(CNT_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .core_req_valid  (core_req_valid),
  .core_req_miss   (core_req_miss),
  .core_req_ready  (core_req_ready),
  .core_resp_valid (core_resp_valid),
  .mshr_free       (mshr_free),
  .wb_free         (wb_free),
  .blocked_cycles  (blocked_cycles)
);

// File: tb/test_llc_admit_front.sv
module test_llc_admit_front;
  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      req_valid = '0, req_miss = '0, req_vd = '0;
  logic [3:0][7:0] req_line = '0, req_vline = '0;
  logic [3:0]      req_ready, resp_valid;
  logic            mq_valid, mq_write, mq_ready = 1'b0;
  logic [7:0]      mq_line;
  logic            rsp_valid = 1'b0;
  logic [7:0]      rsp_line = '0;
  logic [1:0]      mshr_free, wb_free;
  logic [2:0]      blk_cnt;

  int checks = 0, fails = 0, rr_last = 3;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  llc_admit_front #(.NCORES(4), .LINE_W(8), .MSHR_N(2), .WB_N(2), .CNT_W(3)) i_llc_admit_front (
    .clk(clk), .rst(rst),
    .core_req_valid(req_valid), .core_req_line(req_line), .core_req_miss(req_miss),
    .core_req_vic_dirty(req_vd), .core_req_vic_line(req_vline),
    .core_req_ready(req_ready), .core_resp_valid(resp_valid),
    .mem_req_valid(mq_valid), .mem_req_write(mq_write), .mem_req_line(mq_line),
    .mem_req_ready(mq_ready), .mem_rsp_valid(rsp_valid), .mem_rsp_line(rsp_line),
    .mshr_free(mshr_free), .wb_free(wb_free), .blocked_cycles(blk_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input int c, input logic [7:0] ln, input bit miss,
                      input bit vd, input logic [7:0] vl);
    req_valid[c] = 1'b1; req_line[c] = ln; req_miss[c] = miss;
    req_vd[c] = vd; req_vline[c] = vl;
    #1;
    while (!req_ready[c]) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    req_valid[c] = 1'b0; req_miss[c] = 1'b0; req_vd[c] = 1'b0;
    rr_last = c;
  endtask

  task automatic mem_take(input bit wr, input logic [7:0] ln, input string tag);
    chk(mq_valid && mq_write == wr && mq_line == ln, tag,
        {mq_valid, mq_write, mq_line}, {1'b1, wr, ln});
    mq_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    mq_ready = 1'b0;
  endtask

  task automatic refill(input logic [7:0] ln);
    rsp_valid = 1'b1; rsp_line = ln;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1
    chk_eq("R1 mshr_free", mshr_free, 2);
    chk_eq("R1 wb_free", wb_free, 2);
    chk_eq("R1 blocked_cycles", blk_cnt, 0);
    chk_eq("R1 mem/resp idle", {mq_valid, resp_valid}, 0);

    // R2: plain hits from every core
    for (int c = 0; c < 4; c++) begin
      send(c, 8'h40 + 8'(c), 1'b0, 1'b0, 8'h00);
      chk_eq("R2 hit response", resp_valid, 1 << c);
      chk_eq("R2 no memory traffic", mq_valid, 0);
    end

    // R3: miss allocates and reads
    send(0, 8'h10, 1'b1, 1'b0, 8'h00);
    chk_eq("R3 no early response", resp_valid, 0);
    chk_eq("R3 entry taken", mshr_free, 1);
    mem_take(1'b0, 8'h10, "R3 read issued");
    // R4: merge takes nothing
    send(1, 8'h10, 1'b1, 1'b0, 8'h00);
    chk_eq("R4 merge no entry", mshr_free, 1);
    chk_eq("R4 merge no read", mq_valid, 0);
    // R10 / R12: busy core skipped, another core still served
    req_valid[0] = 1'b1; req_line[0] = 8'h44; req_miss[0] = 1'b0;
    send(2, 8'h55, 1'b0, 1'b0, 8'h00);
    chk_eq("R12 hit beside outstanding miss", resp_valid, 4'b0100);
    #1; chk_eq("R10 busy core not granted", req_ready[0], 0);
    @(negedge clk); #1;
    chk_eq("R10 busy core still held", req_ready[0], 0);
    @(negedge clk);
    req_valid[0] = 1'b0;
    refill(8'h10);
    chk_eq("R4 both merged cores answered", resp_valid, 4'b0011);
    chk_eq("R3 entry freed", mshr_free, 2);

    // R5 / R6: dirty victims and port priority
    send(2, 8'h20, 1'b1, 1'b1, 8'h80);
    chk_eq("R5 victim buffered", wb_free, 1);
    chk_eq("R5 table entry", mshr_free, 1);
    mem_take(1'b0, 8'h20, "R6 read before write");
    chk(mq_valid && mq_write && mq_line == 8'h80, "R5 victim write presented",
        {mq_valid, mq_write, mq_line}, {2'b11, 8'h80});
    send(3, 8'h30, 1'b1, 1'b1, 8'h90);
    chk_eq("R5 both full", {mshr_free, wb_free}, 0);
    chk(mq_valid && !mq_write && mq_line == 8'h30, "R6 read overtakes waiting write",
        {mq_valid, mq_write, mq_line}, {2'b10, 8'h30});
    // R7 / R11: full cache refuses everyone
    req_valid[0] = 1'b1; req_line[0] = 8'h41; req_miss[0] = 1'b0;
    req_valid[1] = 1'b1; req_line[1] = 8'h42; req_miss[1] = 1'b0;
    #1; chk_eq("R7 hits refused when full", req_ready, 0);
    repeat (3) @(negedge clk);
    chk_eq("R11 blocked count", blk_cnt, 3);
    repeat (7) @(negedge clk);
    chk_eq("R11 saturates", blk_cnt, 7);
    chk_eq("R7 still refused", req_ready, 0);
    req_valid[0] = 1'b0; req_valid[1] = 1'b0;
    mem_take(1'b0, 8'h30, "R6 second read");
    refill(8'h20);
    chk_eq("R3 refill answer", resp_valid, 4'b0100);
    chk_eq("R3 entry back", mshr_free, 1);
    req_valid[0] = 1'b1;
    #1; chk_eq("R7 victim buffer full alone blocks", req_ready, 0);
    @(negedge clk);
    req_valid[0] = 1'b0;
    mem_take(1'b1, 8'h80, "R5 victim write drained");
    chk_eq("R5 buffer entry freed", wb_free, 1);
    // R8: miss served from victim buffer
    send(1, 8'h90, 1'b1, 1'b1, 8'hA0);
    chk_eq("R8 served from buffer", resp_valid, 4'b0010);
    chk_eq("R8 buffer entry removed, victim ignored", wb_free, 2);
    chk_eq("R8 no table entry", mshr_free, 1);
    chk_eq("R8 line never written", mq_valid, 0);
    refill(8'h30);
    chk_eq("R3 last refill", resp_valid, 4'b1000);
    chk_eq("R11 held after unblock", blk_cnt, 7);

    // R9: rotation sweep from every starting winner
    for (int s = 0; s < 4; s++) begin
      send(s, 8'h50, 1'b0, 1'b0, 8'h00);
      for (int c = 0; c < 4; c++) begin
        req_valid[c] = 1'b1; req_line[c] = 8'h60 + 8'(c); req_miss[c] = 1'b0;
      end
      for (int k = 0; k < 4; k++) begin
        int e;
        e = (rr_last + 1) % 4;
        #1; chk_eq("R9 rotating grant", req_ready, 1 << e);
        @(posedge clk); @(negedge clk);
        req_valid[e] = 1'b0;
        chk_eq("R2 rotation response", resp_valid, 1 << e);
        rr_last = e;
      end
    end

    // R4: merge in the same cycle as the refill
    send(0, 8'h70, 1'b1, 1'b0, 8'h00);
    mem_take(1'b0, 8'h70, "R3 read of colliding line");
    rsp_valid = 1'b1; rsp_line = 8'h70;
    req_valid[1] = 1'b1; req_line[1] = 8'h70; req_miss[1] = 1'b1;
    #1; chk_eq("R4 merge granted on refill cycle", req_ready, 4'b0010);
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0; req_valid[1] = 1'b0; req_miss[1] = 1'b0;
    chk_eq("R4 collision answers both", resp_valid, 4'b0011);
    chk_eq("R4 collision frees entry", mshr_free, 2);
    chk_eq("R4 collision no second read", mq_valid, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule